// File: doc/BRIEF.md
# Rule-Constrained Trigger Pattern Generator

This block produces single-cycle trigger pulses that are aligned to a bunch-crossing counter. The counter wraps at a programmable orbit length, and a marker strobe flags the first crossing of every orbit. Candidate triggers come from one of three places:

- a programmable periodic pattern (first-trigger delay, spacing, triggers per orbit, number of orbits that carry triggers, repeat period in orbits);
- a pseudo-random mode, in which an LFSR is compared against a threshold;
- two active-low pulse inputs, a cable input and a push-button, whose debounced falling edges give one candidate each.

Each candidate must then pass two checks before it becomes a trigger. The first is a throttle gate driven by a four-bit state that is sampled on selected crossings. Its reaction to busy or overflow-warning states can be held back by a programmable delay. The second is four sliding-window rate rules: at most k triggers within N_k crossings, for k = 1..4. A candidate refused by a rule is dropped, not delayed. Each rule has its own saturating counter of the candidates it refused. Register decoding lives outside the block: every setting arrives as a plain input.

Top module: `trig_pattern_gen`

## Requirements
- R1: The crossing counter resets to 0 and counts 0 to orbit_len_i-1, then wraps. orbit_o is high exactly while the counter is 0, so it is high once every orbit_len_i cycles, starting with the first cycle after reset.
- R2: With l1a_en_i high and random mode off, periodic candidates fall on crossings start_dly_i + i*spacing_i for i = 0 .. per_orbit_i-1 that lie inside the orbit. Each issued candidate raises trig_o for one cycle, one cycle later. With l1a_en_i low, pattern and random modes issue nothing.
- R3: With en_burst_i low, at most the first candidate of each orbit is produced (none if per_orbit_i is 0).
- R4: With en_repeat_i low, only the first orbit_max_i orbits after reset carry pattern candidates.
- R5: With en_repeat_i high, the orbit index restarts every repeat_i orbits, and orbits whose index is below orbit_max_i carry candidates.
- R6: Unless no_blank_i is high, pattern and random candidates on the last 119 crossings of an orbit are discarded. Candidates from the external inputs are never blanked.
- R7: In random mode, a candidate occurs on every crossing where the 16-bit LFSR value is less than or equal to rand_thresh_i. The LFSR never holds 0, so a threshold of 0 gives no candidates and a threshold of 0xFFFF gives one on every crossing.
- R8: Rule k (rule_win_i[k-1]) refuses a candidate when k triggers have already been issued and the k-th most recent one lies fewer than rule_win_i[k-1] crossings back. A window of 0 disables the rule. A refused candidate is dropped.
- R9: viol_cnt_o[k-1] counts, with saturation, every candidate that rule k refused. A candidate can count against several rules at once. Candidates stopped by the throttle gate are not counted.
- R10: The throttle state is taken from throttle_i only on crossings where (sample_mask_i AND crossing number) is 0. Ready is 4'b1000, busy is 4'b0100 and overflow warning is 4'b0001. With en_bp_i high, any state other than Ready stops all candidates.
- R11: For busy and overflow warning, blocking starts bp_dly_i cycles after the sampled state leaves Ready. Every other non-Ready code blocks in the first cycle it is sampled. A sampled Ready reopens the gate in the next cycle.
- R12: A falling edge on ext_trig_ni or button_ni that stays low for at least 8 cycles yields exactly one candidate, whatever l1a_en_i is. Shorter low pulses and rising edges yield none.
- R13: During reset, trig_o is 0, all violation counters are 0 and orbit_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Crossing clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| l1a_en_i | input | 1 | Enables pattern and random triggers |
| en_burst_i | input | 1 | Allows more than one trigger per orbit |
| en_repeat_i | input | 1 | Repeats the orbit pattern every repeat_i orbits |
| en_bp_i | input | 1 | Enables the throttle gate |
| en_rand_i | input | 1 | Selects random mode instead of the periodic pattern |
| no_blank_i | input | 1 | Disables blanking of the orbit gap |
| orbit_len_i | input | BX_W | Crossings per orbit |
| start_dly_i | input | BX_W | Crossing of the first trigger in an orbit |
| spacing_i | input | BX_W | Crossings between triggers within an orbit |
| per_orbit_i | input | BX_W | Triggers per orbit |
| orbit_max_i | input | BX_W | Orbits that carry triggers |
| repeat_i | input | BX_W | Repeat period in orbits |
| rand_thresh_i | input | LFSR_W | Random-mode threshold |
| rule_win_i | input | 4 x WIN_W | Window N_k for each rule, entry k-1 for rule k |
| throttle_i | input | 4 | Throttle state |
| sample_mask_i | input | BX_W | Crossing mask for throttle sampling |
| bp_dly_i | input | DLY_W | Delay before busy or warning blocks |
| ext_trig_ni | input | 1 | External trigger, active low |
| button_ni | input | 1 | Push-button trigger, active low |
| trig_o | output | 1 | Issued trigger pulse |
| orbit_o | output | 1 | Orbit-marker strobe |
| viol_cnt_o | output | 4 x CNT_W | Refusal count for each rule |

## Verification
The assertions assume three things about the inputs. Every setting input is held still outside reset. orbit_len_i is at least 2. throttle_i is synchronous to the clock. Under these assumptions, the crossing counter staying below orbit_len_i and the throttle register changing only on sampled crossings are invariants. The stimulus changes configuration only while reset is asserted and drives throttle_i and the pulse inputs at falling clock edges. It keeps spacing nonzero and pattern positions inside the orbit, so the crossing arithmetic never wraps.

// File: rtl/trig_pkg.sv
package trig_pkg;
  localparam int NUM_RULES = 4;

  localparam logic [3:0] THR_READY = 4'b1000;
  localparam logic [3:0] THR_BUSY  = 4'b0100;
  localparam logic [3:0] THR_WARN  = 4'b0001;

  // states whose blocking waits for the programmable delay
  function automatic logic thr_delayed(logic [3:0] s);
    return (s == THR_BUSY) || (s == THR_WARN);
  endfunction
endpackage

// File: rtl/trig_debounce.sv
module trig_debounce #(
  parameter int DEB_LEN = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_ni,
  output logic fall_o
);
  localparam int CW = $clog2(DEB_LEN + 1);

  logic [1:0]    sync_q;
  logic          stable_q;
  logic [CW-1:0] cnt_q;
  logic          fall_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q   <= '1;
      stable_q <= 1'b1;
      cnt_q    <= '0;
      fall_q   <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], in_ni};
      fall_q <= 1'b0;
      if (sync_q[1] == stable_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(DEB_LEN - 1)) begin
        stable_q <= sync_q[1];
        cnt_q    <= '0;
        fall_q   <= !sync_q[1];
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign fall_o = fall_q;

  assert_single_pulse_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/trig_throttle_gate.sv
module trig_throttle_gate import trig_pkg::*; #(
  parameter int BX_W  = 12,
  parameter int DLY_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [3:0]       state_i,
  input  logic [BX_W-1:0]  mask_i,
  input  logic [BX_W-1:0]  bx_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             block_o
);
  logic [3:0]       thr_q;
  logic [DLY_W-1:0] wait_q;
  logic             sample;

  assign sample = (mask_i & bx_i) == '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_q  <= THR_READY;
      wait_q <= '0;
    end else begin
      if (sample) thr_q <= state_i;
      if (thr_q == THR_READY) wait_q <= '0;
      else if (wait_q != '1)  wait_q <= wait_q + 1'b1;
    end
  end

  assign block_o = en_i && (thr_q != THR_READY) &&
                   (!thr_delayed(thr_q) || (wait_q >= dly_i));

  assert_thr_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample |=> $stable(thr_q));
endmodule

// File: rtl/trig_rule_check.sv
module trig_rule_check import trig_pkg::*; #(
  parameter int WIN_W = 12,
  parameter int CNT_W = 16
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  cand_i,
  input  logic [NUM_RULES-1:0][WIN_W-1:0]       win_i,
  output logic                                  issue_o,
  output logic [NUM_RULES-1:0][CNT_W-1:0]       viol_cnt_o
);
  // age_q[k]: crossings since the (k+1)-th most recent issued trigger, saturating
  logic [NUM_RULES-1:0][WIN_W-1:0] age_q;
  logic [NUM_RULES-1:0][CNT_W-1:0] viol_q;
  logic [NUM_RULES-1:0]            viol;

  assign issue_o = cand_i && (viol == '0);

  for (genvar k = 0; k < NUM_RULES; k++) begin : g_rule
    logic [WIN_W-1:0] src;
    if (k == 0) begin : g_head
      assign src = '0;
    end else begin : g_tail
      assign src = age_q[k-1];
    end

    assign viol[k] = cand_i && (age_q[k] < win_i[k]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        age_q[k]  <= '1;
        viol_q[k] <= '0;
      end else begin
        if (issue_o)              age_q[k] <= (src == '1) ? src : src + 1'b1;
        else if (age_q[k] != '1)  age_q[k] <= age_q[k] + 1'b1;
        if (viol[k] && viol_q[k] != '1) viol_q[k] <= viol_q[k] + 1'b1;
      end
    end

    if (k < NUM_RULES - 1) begin : g_ord
      assert_age_order_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        age_q[k] <= age_q[k+1]);
    end
  end

  assign viol_cnt_o = viol_q;

  assert_viol_needs_cand_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cand_i |=> $stable(viol_q));
endmodule

// File: rtl/trig_pattern_gen.sv
module trig_pattern_gen import trig_pkg::*; #(
  parameter int               BX_W     = 12,
  parameter int               WIN_W    = 12,
  parameter int               CNT_W    = 16,
  parameter int               LFSR_W   = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
  parameter int               DLY_W    = 8,
  parameter int               GAP_LEN  = 119,
  parameter int               DEB_LEN  = 8
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            l1a_en_i,
  input  logic                            en_burst_i,
  input  logic                            en_repeat_i,
  input  logic                            en_bp_i,
  input  logic                            en_rand_i,
  input  logic                            no_blank_i,
  input  logic [BX_W-1:0]                 orbit_len_i,
  input  logic [BX_W-1:0]                 start_dly_i,
  input  logic [BX_W-1:0]                 spacing_i,
  input  logic [BX_W-1:0]                 per_orbit_i,
  input  logic [BX_W-1:0]                 orbit_max_i,
  input  logic [BX_W-1:0]                 repeat_i,
  input  logic [LFSR_W-1:0]               rand_thresh_i,
  input  logic [NUM_RULES-1:0][WIN_W-1:0] rule_win_i,
  input  logic [3:0]                      throttle_i,
  input  logic [BX_W-1:0]                 sample_mask_i,
  input  logic [DLY_W-1:0]                bp_dly_i,
  input  logic                            ext_trig_ni,
  input  logic                            button_ni,
  output logic                            trig_o,
  output logic                            orbit_o,
  output logic [NUM_RULES-1:0][CNT_W-1:0] viol_cnt_o
);
  localparam int NSRC = 2;

  logic [BX_W-1:0]   bx_q, next_q, cnt_q, orb_q, target, limit;
  logic [LFSR_W-1:0] lfsr_q;
  logic              wrap, per_hit, rnd_hit, blank, gen, cand, block, issue, trig_q;
  logic [NSRC-1:0]   src_n, ext_fire;

  // orbit and pattern sequencing
  assign wrap    = bx_q >= orbit_len_i - 1'b1;
  assign target  = (cnt_q == '0) ? start_dly_i : next_q;
  assign limit   = en_burst_i ? per_orbit_i : BX_W'(per_orbit_i != '0);
  assign per_hit = (orb_q < orbit_max_i) && (cnt_q < limit) && (bx_q == target);
  assign rnd_hit = lfsr_q <= rand_thresh_i;
  assign blank   = !no_blank_i &&
                   (({1'b0, bx_q} + (BX_W+1)'(GAP_LEN)) >= {1'b0, orbit_len_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bx_q   <= '0;
      orb_q  <= '0;
      cnt_q  <= '0;
      next_q <= '0;
      lfsr_q <= LFSR_W'(1);
    end else begin
      bx_q   <= wrap ? '0 : bx_q + 1'b1;
      lfsr_q <= {1'b0, lfsr_q[LFSR_W-1:1]} ^ (lfsr_q[0] ? LFSR_TAPS : '0);
      if (wrap) begin
        cnt_q <= '0;
        if (en_repeat_i)                orb_q <= (orb_q + 1'b1 >= repeat_i) ? '0 : orb_q + 1'b1;
        else if (orb_q < orbit_max_i)   orb_q <= orb_q + 1'b1;
      end else if (per_hit) begin
        cnt_q  <= cnt_q + 1'b1;
        next_q <= bx_q + spacing_i;
      end
    end
  end

  // external pulse inputs
  assign src_n = {button_ni, ext_trig_ni};
  for (genvar s = 0; s < NSRC; s++) begin : g_src
    trig_debounce #(.DEB_LEN(DEB_LEN)) u_deb (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .in_ni  (src_n[s]),
      .fall_o (ext_fire[s])
    );
  end

  assign gen  = l1a_en_i && !blank && (en_rand_i ? rnd_hit : per_hit);
  assign cand = (gen || (ext_fire != '0)) && !block;

  trig_throttle_gate #(.BX_W(BX_W), .DLY_W(DLY_W)) u_gate (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_bp_i),
    .state_i (throttle_i),
    .mask_i  (sample_mask_i),
    .bx_i    (bx_q),
    .dly_i   (bp_dly_i),
    .block_o (block)
  );

  trig_rule_check #(.WIN_W(WIN_W), .CNT_W(CNT_W)) u_rules (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cand_i     (cand),
    .win_i      (rule_win_i),
    .issue_o    (issue),
    .viol_cnt_o (viol_cnt_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trig_q <= 1'b0;
    else         trig_q <= issue;
  end

  assign trig_o  = trig_q;
  assign orbit_o = bx_q == '0;

  assert_bx_in_orbit_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bx_q < orbit_len_i);
  assert_orbit_once_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (orbit_o && orbit_len_i > 1) |=> !orbit_o);
  assert_quiet_when_off_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> ($past(l1a_en_i) || $past(ext_fire != '0)));
  assert_lfsr_nonzero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lfsr_q != '0);
endmodule

// File: tb/trig_pattern_gen_test.sv
module trig_pattern_gen_test;
  localparam int NR = 4;
  localparam int GAP = 119;

  logic clk = 0, rst_ni = 0;
  logic l1a_en, en_burst, en_repeat, en_bp, en_rand, no_blank;
  logic [11:0] orbit_len, start_dly, spacing, per_orbit, orbit_max, rep, sample_mask;
  logic [15:0] rand_thresh;
  logic [NR-1:0][11:0] rule_win;
  logic [3:0] throttle;
  logic [7:0] bp_dly;
  logic ext_n = 1, btn_n = 1;
  logic trig_o, orbit_o;
  logic [NR-1:0][15:0] viol_cnt_o;

  always #5 clk = ~clk;

  trig_pattern_gen uut (
    .clk_i(clk), .rst_ni(rst_ni), .l1a_en_i(l1a_en), .en_burst_i(en_burst),
    .en_repeat_i(en_repeat), .en_bp_i(en_bp), .en_rand_i(en_rand), .no_blank_i(no_blank),
    .orbit_len_i(orbit_len), .start_dly_i(start_dly), .spacing_i(spacing),
    .per_orbit_i(per_orbit), .orbit_max_i(orbit_max), .repeat_i(rep),
    .rand_thresh_i(rand_thresh), .rule_win_i(rule_win), .throttle_i(throttle),
    .sample_mask_i(sample_mask), .bp_dly_i(bp_dly), .ext_trig_ni(ext_n),
    .button_ni(btn_n), .trig_o(trig_o), .orbit_o(orbit_o), .viol_cnt_o(viol_cnt_o)
  );

  int n_run = 0, n_fail = 0;
  int tnow = 0, win_end = 0, ext_seen = 0, blk_lo = 0, blk_hi = 0, e_t;
  bit ext_mode = 0, orbit_chk = 0;
  string cur_req = "R2";
  int exp_q[$];
  int hist[$];
  int vexp[NR];

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) tnow <= rst_ni ? tnow + 1 : 0;

  // monitor: compares each issued trigger against the scoreboard queue
  always @(negedge clk) begin
    if (rst_ni && trig_o && tnow < win_end) begin
      if (ext_mode) ext_seen++;
      else if (exp_q.size() == 0) chk(0, cur_req, "unexpected trigger at cycle", tnow, -1);
      else begin
        e_t = exp_q.pop_front();
        chk(e_t == tnow, cur_req, "trigger cycle", tnow, e_t);
      end
    end
  end

  // reference model of one candidate
  function automatic void cand(int c);
    bit ok = 1;
    if (c >= win_end || (c >= blk_lo && c < blk_hi)) return;
    for (int k = 0; k < NR; k++)
      if (rule_win[k] != 0 && hist.size() > k && c - hist[k] < int'(rule_win[k])) begin
        vexp[k]++;
        ok = 0;
      end
    if (ok) begin
      hist.push_front(c);
      if (c + 1 < win_end) exp_q.push_back(c + 1);
    end
  endfunction

  function automatic void gen_pattern();
    int L = int'(orbit_len);
    for (int o = 0; o * L < win_end; o++) begin
      bit act = en_repeat ? ((o % int'(rep)) < int'(orbit_max)) : (o < int'(orbit_max));
      int lim = en_burst ? int'(per_orbit) : (per_orbit != 0);
      if (!act) continue;
      for (int i = 0; i < lim; i++) begin
        int p = int'(start_dly) + i * int'(spacing);
        if (p >= L) break;
        if (!no_blank && p + GAP >= L) continue;
        cand(o * L + p);
      end
    end
  endfunction

  function automatic void gen_every();
    for (int c = 0; c < win_end; c++)
      if (no_blank || (c % int'(orbit_len)) + GAP < int'(orbit_len)) cand(c);
  endfunction

  task automatic cfg_default();
    l1a_en = 1; en_burst = 1; en_repeat = 0; en_bp = 0; en_rand = 0; no_blank = 0;
    orbit_len = 200; start_dly = 10; spacing = 20; per_orbit = 3; orbit_max = 1; rep = 1;
    rand_thresh = 0; rule_win = '0; throttle = 4'b1000; sample_mask = 0; bp_dly = 0;
    blk_lo = 0; blk_hi = 0; ext_mode = 0; ext_seen = 0; orbit_chk = 0;
  endtask

  task automatic prep(string req, int len);
    @(negedge clk);
    rst_ni = 0;
    repeat (2) @(negedge clk);
    chk(trig_o == 0, "R13", "trig_o in reset", trig_o, 0);
    chk(orbit_o == 1, "R13", "orbit_o in reset", orbit_o, 1);
    for (int k = 0; k < NR; k++)
      chk(viol_cnt_o[k] == 0, "R13", "violation counter in reset", viol_cnt_o[k], 0);
    cfg_default();
    cur_req = req;
    exp_q.delete();
    hist.delete();
    for (int k = 0; k < NR; k++) vexp[k] = 0;
    win_end = len;
  endtask

  task automatic go();
    @(negedge clk);
    rst_ni = 1;
    while (tnow < win_end) begin
      @(negedge clk);
      if (orbit_chk)
        chk(orbit_o == ((tnow % int'(orbit_len)) == 0), "R1", "orbit strobe", orbit_o,
            (tnow % int'(orbit_len)) == 0);
    end
    chk(exp_q.size() == 0, cur_req, "missing triggers", exp_q.size(), 0);
    for (int k = 0; k < NR; k++)
      chk(viol_cnt_o[k] == vexp[k], "R9", "rule refusal count", viol_cnt_o[k], vexp[k]);
  endtask

  task automatic wait_t(int n);
    while (tnow != n) @(negedge clk);
  endtask

  task automatic rule_run(int w1, int w2, int w3, int w4, int sp);
    prep("R8", 200);
    start_dly = 0; spacing = 12'(sp); per_orbit = 30; no_blank = 1;
    rule_win[0] = 12'(w1); rule_win[1] = 12'(w2); rule_win[2] = 12'(w3); rule_win[3] = 12'(w4);
    gen_pattern();
    go();
  endtask

  task automatic thr_run(logic [3:0] st, int dly, int mask, int t_on, int t_off, int lo, int hi);
    prep("R11", 200);
    start_dly = 0; spacing = 5; per_orbit = 40; no_blank = 1; en_bp = 1;
    bp_dly = 8'(dly); sample_mask = 12'(mask);
    blk_lo = lo; blk_hi = hi;
    if (mask != 0) cur_req = "R10";
    gen_pattern();
    fork
      go();
      begin
        wait_t(t_on); throttle = st;
        wait_t(t_off); throttle = 4'b1000;
      end
    join
  endtask

  task automatic finish_all();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    chk(0, "R1", "watchdog expired at cycle", tnow, -1);
    finish_all();
  end

  initial begin
    cfg_default();

    // R1: orbit strobe on a 150-crossing orbit
    prep("R1", 450);
    orbit_len = 150; l1a_en = 0; orbit_chk = 1;
    go();

    // R2 R4: burst pattern in the first two orbits only
    prep("R4", 1200);
    orbit_max = 2;
    gen_pattern(); go();

    // R3: burst off keeps only the first position
    prep("R3", 1200);
    en_burst = 0; orbit_max = 2;
    gen_pattern(); go();

    // R5: repeating every 3 orbits
    prep("R5", 1400);
    en_repeat = 1; rep = 3; per_orbit = 2;
    gen_pattern(); go();

    // R6: blanking of the orbit gap, then disabled
    prep("R6", 200);
    start_dly = 60; spacing = 15; per_orbit = 4;
    gen_pattern(); go();
    prep("R6", 200);
    start_dly = 60; spacing = 15; per_orbit = 4; no_blank = 1;
    gen_pattern(); go();

    // R2: disabled generator stays quiet
    prep("R2", 400);
    l1a_en = 0;
    go();

    // R8 R9: each rule alone, then all together
    rule_run(5, 0, 0, 0, 3);
    rule_run(0, 10, 0, 0, 3);
    rule_run(0, 0, 10, 0, 3);
    rule_run(0, 0, 0, 100, 3);
    rule_run(2, 8, 12, 20, 1);

    // R7: random threshold boundaries
    prep("R7", 400);
    en_rand = 1; rand_thresh = 16'h0000; no_blank = 1;
    go();
    prep("R7", 200);
    en_rand = 1; rand_thresh = 16'hFFFF; no_blank = 1; rule_win[0] = 7;
    gen_every(); go();
    prep("R6", 400);
    en_rand = 1; rand_thresh = 16'hFFFF; rule_win[0] = 4;
    gen_every(); go();

    // R10 R11: throttle delay, immediate block, sampling mask
    thr_run(4'b0100, 22, 0, 2, 62, 25, 63);
    thr_run(4'b0001, 23, 0, 2, 62, 26, 63);
    thr_run(4'b1100, 22, 0, 2, 62, 3, 63);
    thr_run(4'b0100, 0, 63, 2, 100, 65, 129);

    // R12: debounced external and button pulses
    prep("R12", 300);
    l1a_en = 0; ext_mode = 1;
    fork
      go();
      begin
        wait_t(10);  ext_n = 0;
        wait_t(40);  ext_n = 1;
        wait_t(95);  chk(ext_seen == 1, "R12", "pulses after long external low", ext_seen, 1);
        ext_n = 0;
        wait_t(98);  ext_n = 1;
        wait_t(145); chk(ext_seen == 1, "R12", "pulses after short glitch", ext_seen, 1);
        btn_n = 0;
        wait_t(190); btn_n = 1;
        wait_t(290); chk(ext_seen == 2, "R12", "pulses after button press", ext_seen, 2);
      end
    join

    prep("R13", 10);
    finish_all();
  end
endmodule